// File: doc/BRIEF.md
# Prioritised Locality Ownership Arbiter

This block decides which of several prioritised requesters ("localities") owns a shared security-module register interface at any moment. Each locality writes its own access register through a simple write port tagged with a locality number. A write can ask for use, give up ownership, or claim the interface by force from a lower-numbered owner. The block holds the current owner, or a "none" code. It keeps pending-request and pending-seize flags for each locality and resolves at most one arbitration per clock.

Whenever ownership moves away from a valid locality, the block emits a one-clock abort pulse. A downstream command engine uses it to drop any command that belonged to the old owner. A combinational read port returns any locality's access register so that software can poll its own state.

Top module: `loc_arbiter`

## Requirements
- R1: After a synchronous active-low reset, the owner output is all ones (3'd7, meaning none), abort is low, and the readback of every valid locality is 8'h80.
- R2: With no owner, a locality that has requested use is granted on the clock after its request is registered, and its request flag clears when granted.
- R3: Arbitration runs on every clock that carries no accepted relinquish or seize write. When there is no owner, it grants the highest-numbered pending requester, one grant per clock.
- R4: A write with bit 2 (active) set by the current owner makes the owner none on that clock edge and clears the old owner's request flag. The next pending requester is granted on the following clock.
- R5: A request write (bit 0) from the current owner is ignored. A write with bit 2 set from a non-owner withdraws that locality's pending request.
- R6: A write with bit 1 (seize) set ignores bits 0 and 2 of the same write.
- R7: A seize is accepted only when there is no owner or the writer's number is above the owner's. An accepted seize shows as bit 1 in that locality's readback for one clock. A rejected seize leaves no trace.
- R8: An accepted seize takes ownership on the next clock, unless a still higher seize is pending. The old owner loses its active status, and the request flags of all localities other than the seizer stay unchanged.
- R9: While a seize is pending, no normal request grant is made, even if there is no owner.
- R10: Writes tagged with a locality number of 5 or more are ignored, and reading such a number returns 8'h00.
- R11: Abort is high for exactly the one clock after ownership changes from a valid locality to anything else. It stays low when ownership is taken from the none state.
- R12: Readback layout: bit 0 is the pending request, bit 1 is the pending seize, bit 2 is set when this locality is the owner, bit 3 is set when another locality has a pending request, bit 7 is always 1, and the other bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Access-register write strobe |
| wr_loc | input | 3 | Locality number of the write |
| wr_data | input | 8 | Write data: bit 0 request, bit 1 seize, bit 2 active/relinquish |
| rd_loc | input | 3 | Locality number to read back |
| rd_data | output | 8 | Access-register readback for rd_loc |
| owner | output | 3 | Current owning locality, all ones for none |
| abort | output | 1 | One-clock pulse after ownership leaves a valid locality |

## Verification
The bench builds the block with its defaults: five localities and a 3-bit locality field. With these values the codes 5, 6 and 7 fall outside the supported range, so out-of-range writes and reads can be driven through the normal port. The all-ones none code is also one of those out-of-range values. Five levels of priority are enough to set up a relinquish followed by a choice between two waiting requesters, a rejected lower seize against a middle owner, and a top-level seize that blocks a lower pending request while there is no owner.

// File: rtl/loc_arb_pkg.sv
// Package: shared encodings for the locality ownership arbiter.
// Assumes an 8-bit access register; only the bit positions below carry meaning.
package loc_arb_pkg;
    localparam int ACC_W     = 8;
    localparam int B_REQ     = 0;  // request use / pending request
    localparam int B_SEIZE   = 1;  // seize / pending seize
    localparam int B_ACT     = 2;  // relinquish on write, owner status on read
    localparam int B_PEND    = 3;  // another locality waits (read only)
    localparam int B_VALID   = 7;  // register valid (read only)
endpackage

// File: rtl/loc_arb_wdec.sv
// Module: decodes one access-register write into per-locality actions.
// Assumes the owner code is all ones for "none"; range check comes first.
module loc_arb_wdec
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic             wr_en,
    input  logic [LOC_W-1:0] wr_loc,
    input  logic [ACC_W-1:0] wr_data,
    input  logic [LOC_W-1:0] owner_q,
    output logic             do_req,
    output logic             do_withdraw,
    output logic             do_relinq,
    output logic             do_seize
);
    localparam logic [LOC_W-1:0] NONE = '1;

    logic in_range;
    logic is_owner;
    logic seize_b;

    // Classify the write; a set seize bit masks the other command bits.
    always_comb begin
        in_range    = wr_en && (wr_loc < LOC_W'(NUM_LOC));
        is_owner    = (owner_q == wr_loc);
        seize_b     = wr_data[B_SEIZE];
        do_seize    = in_range && seize_b && ((owner_q == NONE) || (wr_loc > owner_q));
        do_relinq   = in_range && !seize_b && wr_data[B_ACT] && is_owner;
        do_withdraw = in_range && !seize_b && wr_data[B_ACT] && !is_owner;
        do_req      = in_range && !seize_b && wr_data[B_REQ] && !wr_data[B_ACT] && !is_owner;
    end
endmodule

// File: rtl/loc_arb_pick.sv
// Module: priority scan over pending seize and request flags.
// Reports the highest-numbered set flag of each kind; purely combinational.
module loc_arb_pick #(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic [NUM_LOC-1:0] req_q,
    input  logic [NUM_LOC-1:0] seize_q,
    output logic               seize_hit,
    output logic [LOC_W-1:0]   seize_idx,
    output logic               req_hit,
    output logic [LOC_W-1:0]   req_idx
);
    // Ascending scan: the last set flag seen is the highest priority one.
    always_comb begin
        seize_hit = 1'b0;
        seize_idx = '0;
        req_hit   = 1'b0;
        req_idx   = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (seize_q[i]) begin
                seize_hit = 1'b1;
                seize_idx = LOC_W'(i);
            end
            if (req_q[i]) begin
                req_hit = 1'b1;
                req_idx = LOC_W'(i);
            end
        end
    end
endmodule

// File: rtl/loc_arb_rdback.sv
// Module: builds the access-register readback for one locality.
// Assumes out-of-range locality numbers read as all zeros.
module loc_arb_rdback
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic [LOC_W-1:0]   rd_loc,
    input  logic [NUM_LOC-1:0] req_q,
    input  logic [NUM_LOC-1:0] seize_q,
    input  logic [LOC_W-1:0]   owner_q,
    output logic [ACC_W-1:0]   rd_data
);
    // Assemble status bits for the selected locality.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (rd_loc == LOC_W'(i)) begin
                rd_data[B_VALID] = 1'b1;
                rd_data[B_REQ]   = req_q[i];
                rd_data[B_SEIZE] = seize_q[i];
                rd_data[B_ACT]   = (owner_q == rd_loc);
            end
        end
        for (int j = 0; j < NUM_LOC; j++) begin
            if ((rd_loc < LOC_W'(NUM_LOC)) && (rd_loc != LOC_W'(j)) && req_q[j]) begin
                rd_data[B_PEND] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/loc_arbiter.sv
// Module: top of the locality ownership arbiter.
// Holds owner, request and seize state; applies one write and at most one
// arbitration per clock. An accepted relinquish or seize write skips that
// clock's arbitration. Assumes NUM_LOC < 2**LOC_W so all ones means none.
module loc_arbiter
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = $clog2(NUM_LOC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LOC_W-1:0] wr_loc,
    input  logic [ACC_W-1:0] wr_data,
    input  logic [LOC_W-1:0] rd_loc,
    output logic [ACC_W-1:0] rd_data,
    output logic [LOC_W-1:0] owner,
    output logic             abort
);
    localparam logic [LOC_W-1:0] NONE = '1;

    logic [NUM_LOC-1:0] req_q, req_n;
    logic [NUM_LOC-1:0] seize_q, seize_n;
    logic [LOC_W-1:0]   owner_q, owner_n;
    logic               abort_q;
    logic               do_req, do_withdraw, do_relinq, do_seize;
    logic               seize_hit, req_hit;
    logic [LOC_W-1:0]   seize_idx, req_idx;
    logic               skip_arb;

    loc_arb_wdec #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) wdec_i (
        .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data), .owner_q(owner_q),
        .do_req(do_req), .do_withdraw(do_withdraw),
        .do_relinq(do_relinq), .do_seize(do_seize)
    );

    loc_arb_pick #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) pick_i (
        .req_q(req_q), .seize_q(seize_q),
        .seize_hit(seize_hit), .seize_idx(seize_idx),
        .req_hit(req_hit), .req_idx(req_idx)
    );

    loc_arb_rdback #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) rdback_i (
        .rd_loc(rd_loc), .req_q(req_q), .seize_q(seize_q),
        .owner_q(owner_q), .rd_data(rd_data)
    );

    // Next state: write effects first, then this clock's arbitration.
    always_comb begin
        req_n    = req_q;
        seize_n  = seize_q;
        owner_n  = owner_q;
        skip_arb = do_relinq || do_seize;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (wr_loc == LOC_W'(i)) begin
                if (do_req)      req_n[i]   = 1'b1;
                if (do_withdraw) req_n[i]   = 1'b0;
                if (do_relinq)   req_n[i]   = 1'b0;
                if (do_seize)    seize_n[i] = 1'b1;
            end
        end
        if (do_relinq) owner_n = NONE;
        if (!skip_arb) begin
            for (int i = 0; i < NUM_LOC; i++) begin
                if (seize_hit && (seize_idx == LOC_W'(i))) begin
                    seize_n[i] = 1'b0;
                    if ((owner_q == NONE) || (seize_idx > owner_q)) begin
                        owner_n  = seize_idx;
                        req_n[i] = 1'b0;
                    end
                end else if (!seize_hit && req_hit && (owner_q == NONE)
                             && (req_idx == LOC_W'(i))) begin
                    owner_n  = req_idx;
                    req_n[i] = 1'b0;
                end
            end
        end
    end

    // State registers with synchronous reset; abort marks a departure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            seize_q <= '0;
            owner_q <= NONE;
            abort_q <= 1'b0;
        end else begin
            req_q   <= req_n;
            seize_q <= seize_n;
            owner_q <= owner_n;
            abort_q <= (owner_q != NONE) && (owner_n != owner_q);
        end
    end

    assign owner = owner_q;
    assign abort = abort_q;

    // R1: owner is always a supported locality or the none code.
    a_r1_owner_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == NONE) || (owner_q < LOC_W'(NUM_LOC)));

    // R4: an owner's relinquish leaves the interface unowned.
    a_r4_relinq_frees: assert property (@(posedge clk) disable iff (!rst_n)
        do_relinq |=> (owner_q == NONE));

    // R8: an accepted seize write changes no request flag.
    a_r8_seize_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
        do_seize |=> (req_q == $past(req_q)));

    // R10: out-of-range writes produce no action.
    a_r10_bad_loc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_loc >= LOC_W'(NUM_LOC)))
            |-> !(do_req || do_withdraw || do_relinq || do_seize));

    // R11: abort only follows an owner leaving a valid locality.
    a_r11_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_q) |-> (owner_q != $past(owner_q)));
endmodule

// File: tb/loc_arbiter_tb.sv
// Bench: table-driven walk of write/read vectors, then directed reset checks.
module loc_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NROW = 23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_loc = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_loc = '0;
    logic [7:0] rd_data;
    logic [2:0] owner;
    logic       abort;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    loc_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loc(wr_loc),
        .wr_data(wr_data), .rd_loc(rd_loc), .rd_data(rd_data),
        .owner(owner), .abort(abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Fields: we, wloc, wdata, rloc, exp owner, exp abort, exp readback.
    localparam logic [26:0] VEC [NROW] = '{
        {1'b1, 3'd1, 8'h01, 3'd1, 3'd7, 1'b0, 8'h81}, // 0  R12 request visible
        {1'b0, 3'd0, 8'h00, 3'd1, 3'd1, 1'b0, 8'h84}, // 1  R2 grant from none
        {1'b1, 3'd3, 8'h01, 3'd1, 3'd1, 1'b0, 8'h8C}, // 2  R12 pending-other
        {1'b1, 3'd2, 8'h01, 3'd3, 3'd1, 1'b0, 8'h89}, // 3  R12
        {1'b1, 3'd1, 8'h01, 3'd1, 3'd1, 1'b0, 8'h8C}, // 4  R5 owner request ignored
        {1'b1, 3'd1, 8'h04, 3'd1, 3'd7, 1'b1, 8'h88}, // 5  R4 relinquish, R11
        {1'b0, 3'd0, 8'h00, 3'd3, 3'd3, 1'b0, 8'h8C}, // 6  R3 highest wins
        {1'b1, 3'd2, 8'h04, 3'd2, 3'd3, 1'b0, 8'h80}, // 7  R5 withdraw
        {1'b1, 3'd4, 8'h01, 3'd4, 3'd3, 1'b0, 8'h81}, // 8  R3 no grant while owned
        {1'b1, 3'd2, 8'h02, 3'd2, 3'd3, 1'b0, 8'h88}, // 9  R7 lower seize rejected
        {1'b1, 3'd0, 8'h01, 3'd0, 3'd3, 1'b0, 8'h89}, // 10 R12
        {1'b1, 3'd4, 8'h07, 3'd4, 3'd3, 1'b0, 8'h8B}, // 11 R6 R7 seize pending
        {1'b0, 3'd0, 8'h00, 3'd0, 3'd4, 1'b1, 8'h81}, // 12 R8 seize takes over
        {1'b0, 3'd0, 8'h00, 3'd3, 3'd4, 1'b0, 8'h88}, // 13 R8 old owner inactive
        {1'b1, 3'd3, 8'h07, 3'd3, 3'd4, 1'b0, 8'h88}, // 14 R6 request bit masked
        {1'b1, 3'd4, 8'h04, 3'd0, 3'd7, 1'b1, 8'h81}, // 15 R4 R11
        {1'b1, 3'd1, 8'h01, 3'd1, 3'd0, 1'b0, 8'h81}, // 16 R3 grant on request clock
        {1'b1, 3'd0, 8'h04, 3'd0, 3'd7, 1'b1, 8'h88}, // 17 R4
        {1'b1, 3'd4, 8'h02, 3'd4, 3'd7, 1'b0, 8'h8A}, // 18 R9 seize from none
        {1'b0, 3'd0, 8'h00, 3'd1, 3'd4, 1'b0, 8'h81}, // 19 R9 R11 seize beats request
        {1'b1, 3'd6, 8'h01, 3'd6, 3'd4, 1'b0, 8'h00}, // 20 R10
        {1'b1, 3'd5, 8'h02, 3'd4, 3'd4, 1'b0, 8'h8C}, // 21 R10
        {1'b1, 3'd7, 8'h04, 3'd7, 3'd4, 1'b0, 8'h00}  // 22 R10
    };

    function automatic string row_tag(input int r);
        case (r)
            0, 2, 3, 10: return "R12";
            1:           return "R2";
            4, 7:        return "R5";
            5, 15, 17:   return "R4";
            6, 8, 16:    return "R3";
            9:           return "R7";
            11, 14:      return "R6";
            12, 13:      return "R8";
            18, 19:      return "R9";
            default:     return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held by reset
        rd_loc = 3'd2;
        #1;
        check("R1", "owner", {5'd0, owner}, 8'd7);
        check("R1", "abort", {7'd0, abort}, 8'd0);
        check("R1", "readback", rd_data, 8'h80);
        rst_n = 1'b1;
        for (int r = 0; r < NROW; r++) begin
            wr_en   = VEC[r][26];
            wr_loc  = VEC[r][25:23];
            wr_data = VEC[r][22:15];
            rd_loc  = VEC[r][14:12];
            @(negedge clk);
            check(row_tag(r), $sformatf("row %0d owner", r), {5'd0, owner}, {5'd0, VEC[r][11:9]});
            check((r == 5 || r == 12 || r == 19) ? "R11" : row_tag(r),
                  $sformatf("row %0d abort", r), {7'd0, abort}, {7'd0, VEC[r][8]});
            check(row_tag(r), $sformatf("row %0d readback", r), rd_data, VEC[r][7:0]);
        end
        wr_en = 1'b0;
        // R1: mid-run reset clears owner and pending request of locality 1
        rst_n = 1'b0;
        rd_loc = 3'd1;
        repeat (2) @(negedge clk);
        check("R1", "owner after reset", {5'd0, owner}, 8'd7);
        check("R1", "readback after reset", rd_data, 8'h80);
        check("R1", "abort after reset", {7'd0, abort}, 8'd0);
        rst_n = 1'b1;
        // R2: recovery, request then grant
        wr_en = 1'b1; wr_loc = 3'd2; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2", "owner before grant", {5'd0, owner}, 8'd7);
        @(negedge clk);
        check("R2", "owner after grant", {5'd0, owner}, 8'd2);
        check("R11", "no abort on grant from none", {7'd0, abort}, 8'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule